// File: doc/BRIEF.md
# Three-Voice Restart-PWM Sample Sequencer

This block turns a stream of 8-bit audio samples into pulse-width modulated output. It does not compare each sample against a counter of its own. Instead it drives three free-running pulse oscillators. Each oscillator holds an accumulator that advances by a fixed frequency word every clock. Its pulse output stays high while the top bits of the accumulator are below a pulse-width value. A test control clears the accumulator and, while it is held, forces the pulse output high.

For every sample the sequencer writes a pulse width into each voice and holds the test control for a short window, which restarts all three accumulators together. It then lets them run for the rest of the frame before it takes the next sample. The three voices are given the sample plus a small offset each. Because of these offsets, the voices end their high phases on neighbouring clocks, and that adds resolution below the 4-count step of one oscillator.

The output is a small multi-level code: the number of voice pulses that are high. Samples arrive over a valid/ready handshake. An enable input starts playback, and dropping it stops playback cleanly at the end of the current frame.

Top module: `pwm_sample_seq`

## Requirements
- R1: While playing, a frame lasts exactly 68 clocks, so accepted-sample slots (inReady high) are exactly 68 clocks apart.
- R2: The test control of all voices is held during the first 4 clocks of each frame, so level equals 3 for those 4 frame clocks.
- R3: After the test window, a voice with pulse width W stays high for ceil(W/4) of the 64 remaining clocks. Its accumulator adds 0x4000 per clock, so the 12-bit compare value rises by 4 per clock.
- R4: Voice k (k = 0, 1, 2) uses the pulse width min(sample + k, 255).
- R5: The pulse width is 12 bits: the sample fills the low 8 bits and the upper 4 bits are zero. A sample of 255 therefore keeps every voice high for the whole frame.
- R6: If inValid is low in the accepting clock, the previously accepted sample is played again. The stored sample resets to 0.
- R7: inReady is high only in the last clock of a frame while enable is high, or in an idle clock while enable is high. A sample is taken when inReady and inValid are both high in the same clock.
- R8: When enable is high in an idle clock, that clock accepts a sample and the next clock is frame clock 0.
- R9: When enable is low, the current frame runs to its end with no sample accepted. The block then goes idle, with inReady low and all test controls held, so level reads 3.
- R10: level is registered: it shows the number of high voice pulses from the previous clock, saturated at 3. In reset, level is 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Starts playback; low stops it at a frame end |
| inValid | input | 1 | A sample is offered on inData |
| inData | input | 8 | Sample value |
| inReady | output | 1 | Sample slot open this clock |
| level | output | 2 | Count of high voice pulses, one clock late |

## Verification
The bench compares the output of every clock in each frame with a per-phase model. An off-by-one in the test window or the frame length therefore shows up as a shifted staircase rather than a small error. It targets the saturation corners (samples 253 to 255, where the voice offsets clip), samples of 0 to 4, where a voice drops on the first run clock or never rises, and the carry points 3/4 and 251/252, where a voice with no offset would end one clock early. It also checks replay when no sample is offered. Finally, it stops playback mid-frame: a block that stopped at once would truncate the frame, and one that missed the stop would raise inReady again.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  typedef struct packed {
    logic testHold;
    logic loadSample;
  } seqStrobes_t;

  function automatic int unsigned satAdd(int unsigned a, int unsigned b, int unsigned maxVal);
    int unsigned s;
    s = a + b;
    return (s > maxVal) ? maxVal : s;
  endfunction
endpackage

// File: rtl/pwm_voice.sv
module pwm_voice #(
  parameter int ACC_W = 24,
  parameter int PW_W = 12,
  parameter int FREQ_W = 16,
  parameter logic [FREQ_W-1:0] FREQ_WORD = 16'h4000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            testHold,
  input  logic [PW_W-1:0] pulseWidth,
  output logic            pulseOut
);
  logic [ACC_W-1:0] acc;
  logic [PW_W-1:0] accTop;

  always_ff @(posedge clk) begin
    if (!rstN)         acc <= '0;
    else if (testHold) acc <= '0;
    else               acc <= acc + ACC_W'(FREQ_WORD);
  end

  assign accTop   = acc[ACC_W-1 -: PW_W];
  assign pulseOut = testHold | (accTop < pulseWidth);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import pwm_seq_pkg::*;
#(
  parameter int TEST_CYCLES = 4,
  parameter int RUN_CYCLES = 64,
  localparam int FRAME = TEST_CYCLES + RUN_CYCLES,
  localparam int PH_W = $clog2(FRAME)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            inValid,
  output logic            inReady,
  output logic            running,
  output logic [PH_W-1:0] phase,
  output seqStrobes_t     strobes
);
  localparam logic [PH_W-1:0] LAST = PH_W'(FRAME - 1);
  localparam logic [PH_W-1:0] TEST_END = PH_W'(TEST_CYCLES);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state;
  logic atLast;

  assign atLast  = (state == ST_RUN) && (phase == LAST);
  assign inReady = enable && ((state == ST_IDLE) || atLast);
  assign running = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= '0;
    end else if (inReady) begin
      state <= ST_RUN;
      phase <= '0;
    end else if (atLast) begin
      state <= ST_IDLE;
      phase <= '0;
    end else if (state == ST_RUN) begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    strobes.testHold   = (state == ST_IDLE) || (phase < TEST_END);
    strobes.loadSample = inReady && inValid;
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import pwm_seq_pkg::*;
#(
  parameter int NUM_VOICES = 3,
  parameter int SAMPLE_W = 8,
  parameter int ACC_W = 24,
  parameter int PW_W = 12,
  parameter int FREQ_W = 16,
  parameter logic [FREQ_W-1:0] FREQ_WORD = 16'h4000,
  localparam int LVL_W = $clog2(NUM_VOICES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strobes,
  input  logic [SAMPLE_W-1:0] inData,
  output logic [SAMPLE_W-1:0] curSample,
  output logic [LVL_W-1:0]    level
);
  localparam int unsigned SAMPLE_MAX = (1 << SAMPLE_W) - 1;
  localparam int unsigned LVL_MAX = (1 << LVL_W) - 1;

  logic [NUM_VOICES-1:0] pulses;

  always_ff @(posedge clk) begin
    if (!rstN)                   curSample <= '0;
    else if (strobes.loadSample) curSample <= inData;
  end

  for (genvar k = 0; k < NUM_VOICES; k++) begin : g_voice
    logic [PW_W-1:0] pw;
    always_comb begin
      pw = PW_W'(satAdd(int'(curSample), k, SAMPLE_MAX));
    end
    pwm_voice #(
      .ACC_W(ACC_W), .PW_W(PW_W), .FREQ_W(FREQ_W), .FREQ_WORD(FREQ_WORD)
    ) u_voice (
      .clk(clk), .rstN(rstN), .testHold(strobes.testHold),
      .pulseWidth(pw), .pulseOut(pulses[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) level <= '0;
    else       level <= LVL_W'(satAdd($countones(pulses), 0, LVL_MAX));
  end
endmodule

// File: rtl/pwm_sample_seq.sv
module pwm_sample_seq
  import pwm_seq_pkg::*;
#(
  parameter int NUM_VOICES = 3,
  parameter int SAMPLE_W = 8,
  parameter int TEST_CYCLES = 4,
  parameter int RUN_CYCLES = 64,
  parameter int ACC_W = 24,
  parameter int PW_W = 12,
  parameter int FREQ_W = 16,
  parameter logic [FREQ_W-1:0] FREQ_WORD = 16'h4000,
  localparam int LVL_W = $clog2(NUM_VOICES + 1),
  localparam int PH_W = $clog2(TEST_CYCLES + RUN_CYCLES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inData,
  output logic                inReady,
  output logic [LVL_W-1:0]    level
);
  seqStrobes_t strobes;
  logic running;
  logic [PH_W-1:0] phase;
  logic [SAMPLE_W-1:0] curSample;

  seq_ctrl #(.TEST_CYCLES(TEST_CYCLES), .RUN_CYCLES(RUN_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .inValid(inValid),
    .inReady(inReady), .running(running), .phase(phase), .strobes(strobes)
  );

  seq_datapath #(
    .NUM_VOICES(NUM_VOICES), .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .PW_W(PW_W),
    .FREQ_W(FREQ_W), .FREQ_WORD(FREQ_WORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inData(inData),
    .curSample(curSample), .level(level)
  );
endmodule

// File: rtl/pwm_seq_checker.sv
module pwm_seq_checker #(
  parameter int SAMPLE_W = 8,
  parameter int TEST_CYCLES = 4,
  parameter int RUN_CYCLES = 64,
  parameter int LVL_W = 2,
  parameter int PH_W = 7
) (
  input logic                clk,
  input logic                rstN,
  input logic                inReady,
  input logic                inValid,
  input logic [LVL_W-1:0]    level,
  input logic                running,
  input logic [PH_W-1:0]     phase,
  input logic [SAMPLE_W-1:0] curSample
);
  localparam logic [PH_W-1:0] LAST = PH_W'(TEST_CYCLES + RUN_CYCLES - 1);
  localparam logic [PH_W-1:0] TEST_END = PH_W'(TEST_CYCLES);
  localparam logic [LVL_W-1:0] ALL_HIGH = LVL_W'(3);

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (running && phase != LAST) |=> (running && phase == $past(phase) + 1'b1)); // R1
  AST_TEST_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (running && phase < TEST_END) |=> (level == ALL_HIGH)); // R2
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && inValid) |=> $stable(curSample)); // R6
  AST_READY_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && running) |-> (phase == LAST)); // R7
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> (level == ALL_HIGH)); // R9
endmodule

bind pwm_sample_seq pwm_seq_checker #(
  .SAMPLE_W(SAMPLE_W), .TEST_CYCLES(TEST_CYCLES), .RUN_CYCLES(RUN_CYCLES),
  .LVL_W(LVL_W), .PH_W(PH_W)
) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .inValid(inValid), .level(level),
  .running(running), .phase(phase), .curSample(curSample)
);

// File: tb/sim_pwm_sample_seq.sv
`timescale 1ns/1ps
module sim_pwm_sample_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = 8'd0;
  logic inReady;
  logic [1:0] level;

  int nChecks = 0;
  int nFails = 0;
  int expSample = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pwm_sample_seq u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .inValid(inValid),
    .inData(inData), .inReady(inReady), .level(level)
  );

  function automatic int expLevel(int s, int p);
    int n = 0;
    if (p < 4) return 3;
    for (int k = 0; k < 3; k++) begin
      int pw = (s + k > 255) ? 255 : s + k;
      if (4 * (p - 4) < pw) n++;
    end
    return n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // Entry: just sampled a negedge where inReady was high (handshake at next edge).
  task automatic runFrame(bit nValid, int nData, bit dropEn);
    bit shapeOk = 1'b1;
    int badP = 0, badAct = 0, badExp = 0;
    int s = expSample;
    for (int i = 1; i <= 68; i++) begin
      @(negedge clk);
      if (i == 1) begin
        inValid = nValid;
        inData = 8'(nData);
        if (dropEn) enable = 1'b0;
      end
      if (i >= 2 && shapeOk && int'(level) != expLevel(s, i - 2)) begin
        shapeOk = 1'b0; badP = i - 2; badAct = int'(level); badExp = expLevel(s, i - 2);
      end
      if (i < 68 && inReady) check(1'b0, "R1/R7 early ready", 1, 0);
    end
    if (!shapeOk) $display("  phase %0d sample %0d", badP, s);
    check(shapeOk, "R2/R3/R4/R5 frame shape", badAct, badExp);
    check(inReady == !dropEn, dropEn ? "R9 no ready at stop" : "R1/R7 ready at 68",
          int'(inReady), int'(!dropEn));
    if (inReady && inValid) expSample = int'(inData);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      summary();
    end
  end

  initial begin
    int dir[12] = '{0, 1, 2, 3, 4, 5, 251, 252, 253, 254, 255, 128};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(inReady == 1'b0 && level == 2'd0, "R10 reset state", int'(level), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(level == 2'd3 && !inReady, "R9/R10 idle after reset", int'(level), 3);
    inValid = 1'b1; inData = 8'd0; enable = 1'b1;
    #1;
    check(inReady, "R8 ready when idle and enabled", int'(inReady), 1);
    if (inReady && inValid) expSample = int'(inData);
    @(negedge clk);
    // first frame: drive the first directed value at next slot
    for (int j = 0; j < 12; j++) begin
      // align: we are one negedge past a handshake; finish frame via runFrame-like loop
      if (j == 0) begin
        bit ok = 1'b1;
        inData = 8'(dir[0]);
        for (int i = 2; i <= 68; i++) begin
          @(negedge clk);
          if (int'(level) != expLevel(expSample, i - 2)) ok = 1'b0;
        end
        check(ok, "R8 first frame shape", 0, 0);
        check(inReady, "R1 first slot", int'(inReady), 1);
        expSample = int'(inData);
      end
      runFrame(1'b1, dir[(j + 1) % 12], 1'b0);
    end
    // replay: no valid data offered
    runFrame(1'b0, 8'd77, 1'b0);
    runFrame(1'b1, 8'd200, 1'b0);
    check(expSample == 200, "R6 replay then resume", expSample, 200);
    for (int j = 0; j < 120; j++) begin
      bit v = ($urandom % 4) != 0;
      runFrame(v, int'($urandom % 256), 1'b0);
    end
    // stop mid-playback
    runFrame(1'b1, 8'd90, 1'b1);
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(level == 2'd3 && !inReady, "R9 idle hold", int'(level), 3);
    end
    enable = 1'b1; inValid = 1'b1; inData = 8'd254;
    #1;
    check(inReady, "R8 restart ready", int'(inReady), 1);
    expSample = 254;
    @(negedge clk);
    begin
      bit ok = 1'b1;
      for (int i = 2; i <= 68; i++) begin
        @(negedge clk);
        if (int'(level) != expLevel(254, i - 2)) ok = 1'b0;
      end
      check(ok, "R8/R4 restart frame shape", 0, 0);
    end
    summary();
  end
endmodule